// File: doc/BRIEF.md
# Row-Scan Sequencer with Double Sampling

The block steps through the rows of a pixel matrix, one row at a time, and reads every column of the current row twice. First it drives the row's select strobe and captures a parallel word of digitized column samples. These samples hold the collected charge on top of each column's baseline. Then it pulses the row's clear strobe and captures a second word, which holds the baseline alone. For each column it subtracts the second sample from the first.

Only columns whose difference is positive and strictly above a programmable threshold leave the block. Each one leaves as a hit record carrying the row, the column and the difference. Hits are offered on a valid/ready handshake, and the scan waits while the consumer holds ready low.

A row with no hits takes five clock cycles. A row with hits takes one extra cycle per hit. After the last row the scan returns to row 0 and raises a one-cycle frame marker. Analog conversion and the strobe level shifters sit outside the block.

Top module: `rowscan_dsamp`

## Requirements
- R1: While reset is held, select strobe 0 is the only strobe active, no clear strobe is active, hit_valid is 0 and frame_done is 0.
- R2: Each row follows this order: select, first sample, clear, second sample, emit. The row's select strobe stays active from the select step through the second sample. Its clear strobe is active for exactly one cycle, between the two samples, and only together with the same row's select. A sample step captures samp_bus only in a cycle with samp_strobe high and waits otherwise.
- R3: At most one select strobe and at most one clear strobe are active in any cycle.
- R4: A column's value is first sample minus second sample. It is a hit only when that value is positive and strictly greater than thresh. An equal value is suppressed, and so is a zero or negative value.
- R5: Hits leave in ascending row order. Within a row they leave in ascending column order. hit_row gives the row index, hit_col gives the column index (column c is samp_bus bits [c*DW +: DW]), and hit_value gives the difference.
- R6: While hit_valid is high and hit_ready is low, hit_row, hit_col and hit_value hold steady and no select strobe is active. A hit is consumed in a cycle where hit_valid and hit_ready are both high.
- R7: When the emit step of the last row finds no hit left, the scan moves to row 0. frame_done is high for exactly that one cycle, the cycle in which row 0's select step begins. Every frame visits all rows.
- R8: With samp_strobe held high, a row with no hits starts its select step exactly 5 cycles after the previous row's select step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh | input | DW | Hit threshold; a hit's difference must be strictly greater |
| samp_strobe | input | 1 | samp_bus holds a valid sample word this cycle |
| samp_bus | input | COLS*DW | One DW-bit sample per column, column c at bits [c*DW +: DW] |
| sel_row | output | ROWS | Per-row select strobes, one-hot or zero |
| clr_row | output | ROWS | Per-row clear strobes, one-hot or zero |
| hit_valid | output | 1 | A hit record is offered |
| hit_ready | input | 1 | Consumer accepts the offered hit |
| hit_row | output | $clog2(ROWS) | Row of the offered hit |
| hit_col | output | $clog2(COLS) | Column of the offered hit |
| hit_value | output | DW | First sample minus second sample |
| frame_done | output | 1 | One-cycle marker on wrap back to row 0 |

## Verification
The bench targets the threshold edge in both directions. A difference equal to the threshold must be dropped, and a difference one above it must be kept; an off-by-one compare loses or adds a full row of records. It also sends negative differences at large magnitude and zero differences at threshold 0, which a design with unsigned wrap-around would report as huge hits. A fully populated row tests column 0, column 127 and back-to-back emission. Single hits at either end of a row catch a priority encoder that scans the wrong way.

The bench drives garbage on the sample bus whenever the strobe is low. A sequencer that samples without waiting would therefore report wrong values. Random backpressure exposes any hit that changes or is lost while stalled. The row-period and frame-wrap checks catch extra or missing sequencing states.

// File: rtl/rowscan_dsamp.sv
module rowscan_dsamp #(
  parameter int ROWS = 64,
  parameter int COLS = 128,
  parameter int DW   = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DW-1:0]           thresh,
  input  logic                    samp_strobe,
  input  logic [COLS*DW-1:0]      samp_bus,
  output logic [ROWS-1:0]         sel_row,
  output logic [ROWS-1:0]         clr_row,
  output logic                    hit_valid,
  input  logic                    hit_ready,
  output logic [$clog2(ROWS)-1:0] hit_row,
  output logic [$clog2(COLS)-1:0] hit_col,
  output logic [DW-1:0]           hit_value,
  output logic                    frame_done
);
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  typedef enum logic [2:0] {ST_SEL, ST_S1, ST_CLR, ST_S2, ST_EMIT} st_t;

  st_t            st;
  logic [RW-1:0]  row;
  logic [DW-1:0]  first_q [COLS];
  logic [DW-1:0]  val_q   [COLS];
  logic [COLS-1:0] mask;
  logic [DW-1:0]  dval [COLS];
  logic [COLS-1:0] dhit;
  logic [CW-1:0]  pick;
  logic [ROWS-1:0] row_bit;

  genvar g;
  generate
    for (g = 0; g < COLS; g++) begin : g_col
      logic [DW:0] diff;
      assign diff    = {1'b0, first_q[g]} - {1'b0, samp_bus[g*DW +: DW]};
      assign dval[g] = diff[DW-1:0];
      assign dhit[g] = !diff[DW] && (diff[DW-1:0] > thresh);
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int i = COLS - 1; i >= 0; i--)
      if (mask[i]) pick = CW'(i);
  end

  assign row_bit   = {{(ROWS-1){1'b0}}, 1'b1} << row;
  assign sel_row   = (st != ST_EMIT) ? row_bit : '0;
  assign clr_row   = (st == ST_CLR)  ? row_bit : '0;
  assign hit_valid = (st == ST_EMIT) && (|mask);
  assign hit_row   = row;
  assign hit_col   = pick;
  assign hit_value = val_q[pick];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_SEL;
      row        <= '0;
      mask       <= '0;
      frame_done <= 1'b0;
      for (int i = 0; i < COLS; i++) begin
        first_q[i] <= '0;
        val_q[i]   <= '0;
      end
    end else begin
      frame_done <= 1'b0;
      case (st)
        ST_SEL: st <= ST_S1;
        ST_S1: if (samp_strobe) begin
          for (int i = 0; i < COLS; i++) first_q[i] <= samp_bus[i*DW +: DW];
          st <= ST_CLR;
        end
        ST_CLR: st <= ST_S2;
        ST_S2: if (samp_strobe) begin
          for (int i = 0; i < COLS; i++) val_q[i] <= dval[i];
          mask <= dhit;
          st   <= ST_EMIT;
        end
        ST_EMIT: begin
          if (|mask) begin
            if (hit_ready) mask[pick] <= 1'b0;
          end else begin
            st         <= ST_SEL;
            row        <= (row == LAST_ROW) ? '0 : row + 1'b1;
            frame_done <= (row == LAST_ROW);
          end
        end
        default: st <= ST_SEL;
      endcase
    end
  end
endmodule

// File: rtl/rowscan_dsamp_chk.sv
module rowscan_dsamp_chk #(
  parameter int ROWS = 64,
  parameter int COLS = 128,
  parameter int DW   = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ROWS-1:0]         sel_row,
  input logic [ROWS-1:0]         clr_row,
  input logic                    hit_valid,
  input logic                    hit_ready,
  input logic [$clog2(ROWS)-1:0] hit_row,
  input logic [$clog2(COLS)-1:0] hit_col,
  input logic [DW-1:0]           hit_value,
  input logic                    frame_done
);
  a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_row));
  a_r3_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(clr_row));
  a_r2_clr_under_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_row) |-> (clr_row == sel_row));
  a_r2_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_row) |=> (clr_row == '0));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !hit_ready) |=> (hit_valid && $stable(hit_row) && $stable(hit_col) && $stable(hit_value)));
  a_r6_no_sel_while_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (sel_row == '0));
  a_r5_col_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_ready) |=> (!hit_valid || (hit_col > $past(hit_col))));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  a_r7_done_row0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> sel_row[0]);
endmodule

bind rowscan_dsamp rowscan_dsamp_chk #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_row(sel_row), .clr_row(clr_row),
  .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_row(hit_row),
  .hit_col(hit_col), .hit_value(hit_value), .frame_done(frame_done)
);

// File: tb/rowscan_dsamp_tb.sv
module rowscan_dsamp_tb;
  localparam int ROWS = 64;
  localparam int COLS = 128;
  localparam int DW   = 12;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 6;
  localparam int LIMIT = 150000;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] thresh = '0;
  logic samp_strobe = 1'b1;
  logic [COLS*DW-1:0] samp_bus = '0;
  logic [ROWS-1:0] sel_row, clr_row;
  logic hit_valid, hit_ready = 1'b1;
  logic [$clog2(ROWS)-1:0] hit_row;
  logic [$clog2(COLS)-1:0] hit_col;
  logic [DW-1:0] hit_value;
  logic frame_done;

  rowscan_dsamp #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .samp_strobe(samp_strobe),
    .samp_bus(samp_bus), .sel_row(sel_row), .clr_row(clr_row),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_row(hit_row),
    .hit_col(hit_col), .hit_value(hit_value), .frame_done(frame_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  int s1m [ROWS][COLS];
  int s2m [ROWS][COLS];
  int exp_row [ROWS*COLS];
  int exp_col [ROWS*COLS];
  int exp_val [ROWS*COLS];
  int exp_n = 0, exp_i = 0, fr = 0, thr = 0;
  int rs = 1, last_start = -1;
  logic cl = 0, prev_sel_zero = 0, prev_clr = 0;
  logic stall_pend = 0;
  logic [$clog2(ROWS)-1:0] st_row;
  logic [$clog2(COLS)-1:0] st_col;
  logic [DW-1:0] st_val;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clampv(input int v);
    return (v < 0) ? 0 : (v > MAXV) ? MAXV : v;
  endfunction

  function automatic bit is_hit(input int a, input int b, input int t);
    return (a > b) && (a - b > t);
  endfunction

  task automatic rand_row(input int r);
    for (int c = 0; c < COLS; c++) begin
      int ped, sig, k;
      ped = 100 + int'($urandom % 200);
      k = int'($urandom % 100);
      if (k < 5) sig = thr + 1 + int'($urandom % 500);
      else sig = int'($urandom % 41) - 20;
      s2m[r][c] = ped;
      s1m[r][c] = clampv(ped + sig);
    end
  endtask

  task automatic gen_frame(input int f);
    if (f == 0) thr = MAXV;
    else if (f == 1) thr = 20;
    else if (f == 2) thr = 0;
    else thr = 10 + int'($urandom % 50);
    for (int r = 0; r < ROWS; r++) rand_row(r);
    if (f == 0)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) s1m[r][c] = s2m[r][c] + 3;
    if (f == 1) begin
      for (int c = 0; c < COLS; c++) begin
        s2m[0][c] = 100; s1m[0][c] = 121;
        s2m[1][c] = 100; s1m[1][c] = 120;
        s2m[2][c] = 300; s1m[2][c] = 100;
        s2m[3][c] = 50;  s1m[3][c] = 50;
        s2m[4][c] = 50;  s1m[4][c] = 50;
      end
      s1m[3][COLS-1] = MAXV; s2m[3][COLS-1] = 0;
      s1m[4][0] = 90; s2m[4][0] = 60;
    end
    if (f == 2) begin
      for (int c = 0; c < COLS; c++) begin s2m[0][c] = 77; s1m[0][c] = 77; end
      s1m[0][5] = 78; s1m[0][64] = 78;
    end
    exp_n = 0; exp_i = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (is_hit(s1m[r][c], s2m[r][c], thr)) begin
          exp_row[exp_n] = r; exp_col[exp_n] = c;
          exp_val[exp_n] = s1m[r][c] - s2m[r][c];
          exp_n++;
        end
    thresh = DW'(thr);
  endtask

  always @(negedge clk) begin
    if (rst_n && fr < NF) begin
      int r;
      bit started;
      started = prev_sel_zero && (sel_row != '0);
      if (frame_done) begin
        chk(exp_i == exp_n, "R5 all hits of frame consumed", exp_i, exp_n);
        chk(rs == ROWS, "R7 rows visited per frame", rs, ROWS);
        chk(sel_row == ROWS'(1), "R7 wrap to row 0", int'(sel_row[0]), 1);
        fr++;
        rs = 1;
        last_start = -1;
        if (fr < NF) gen_frame(fr);
      end else if (started) begin
        rs++;
        if (fr == 0 && last_start >= 0)
          chk(cyc - last_start == 5, "R8 row period", cyc - last_start, 5);
        last_start = cyc;
      end else if (started == 0 && fr == 0 && last_start < 0 && sel_row != '0 && rs > 1) begin
        last_start = -1;
      end
      if (started && !frame_done && fr == 0 && last_start < 0) last_start = cyc;
      if (clr_row != '0) begin
        chk(clr_row == sel_row, "R2 clear with same row select", int'(clr_row != sel_row), 0);
        chk(!prev_clr, "R2 clear lasts one cycle", int'(prev_clr), 0);
      end
      if (stall_pend) begin
        chk(hit_valid && hit_row == st_row && hit_col == st_col && hit_value == st_val,
            "R6 hit held while stalled", int'(hit_col), int'(st_col));
        chk(sel_row == '0, "R6 scan stalled", int'(sel_row != '0), 0);
      end
      if (sel_row == '0) cl = 0;
      if (clr_row != '0) cl = 1;
      r = 0;
      for (int i = 0; i < ROWS; i++) if (sel_row[i]) r = i;
      hit_ready   = (fr < 2) ? 1'b1 : ($urandom % 4 != 0);
      samp_strobe = (fr < 3) ? 1'b1 : ($urandom % 3 != 0);
      for (int c = 0; c < COLS; c++)
        samp_bus[c*DW +: DW] = samp_strobe ? DW'(cl ? s2m[r][c] : s1m[r][c]) : DW'($urandom);
      if (hit_valid && hit_ready) begin
        if (exp_i < exp_n) begin
          chk(int'(hit_row) == exp_row[exp_i], "R5 hit row", int'(hit_row), exp_row[exp_i]);
          chk(int'(hit_col) == exp_col[exp_i], "R5 hit column", int'(hit_col), exp_col[exp_i]);
          chk(int'(hit_value) == exp_val[exp_i], "R4 hit value", int'(hit_value), exp_val[exp_i]);
        end else
          chk(0, "R4 unexpected hit", int'(hit_col), -1);
        exp_i++;
      end
      stall_pend = hit_valid && !hit_ready;
      st_row = hit_row; st_col = hit_col; st_val = hit_value;
      prev_sel_zero = (sel_row == '0);
      prev_clr = (clr_row != '0);
    end
  end

  initial begin
    void'($urandom(32'd24601));
    gen_frame(0);
    repeat (3) @(negedge clk);
    chk(sel_row == ROWS'(1), "R1 reset select row 0", int'(sel_row[0]), 1);
    chk(clr_row == '0, "R1 reset clear idle", int'(clr_row != '0), 0);
    chk(!hit_valid, "R1 reset hit_valid", int'(hit_valid), 0);
    chk(!frame_done, "R1 reset frame_done", int'(frame_done), 0);
    rst_n = 1;
    while (fr < NF && cyc < LIMIT) @(posedge clk);
    if (fr < NF) chk(0, "watchdog frames completed", fr, NF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule